// File: doc/BRIEF.md
# Serial Halfband Decimator

This block halves the sample rate of one real sample stream with an 11-tap halfband low-pass filter. Samples arrive as signed 18-bit words (16 fractional bits), qualified by a valid strobe, and are sparse: several idle clocks separate any two of them. A single multiplier is enough because the filter is computed over those idle clocks. Zero-valued taps are never visited, and each symmetric pair of samples is summed before it reaches the multiplier. The centre tap of one half is applied as a shift, not as a product.

The filter runs once for every second accepted sample. The centre term and the three pre-added pair products are accumulated at full precision. The sum is then scaled back to the sample format by truncation, and an out-of-range result wraps. One 18-bit result with a single-cycle strobe leaves the block for each pair of inputs.

Top module: `hb_decim_serial`

## Requirements
- R1: While reset is asserted and right after it is released, `valid_o` is 0 and `data_o` is 0.
- R2: An output is produced for exactly the 2nd, 4th, 6th, ... accepted input counted from reset, and for no other input.
- R3: `valid_o` is high for exactly one clock. It rises on the 3rd rising edge after the edge that accepted the triggering input, which is 4 edges after that input was driven.
- R4: The output equals the filter sum y = sum over k=0..10 of h[k]*x[n-k], with h = {292, 0, -1851, 0, 9755, 16384, 9755, 0, -1851, 0, 292}. Here x[n] is the triggering input, the coefficients are Q15 and the samples Q16. Samples older than the last reset count as zero.
- R5: The full-precision sum is reduced to the output by dropping its 15 low bits and keeping the next 18 bits. A sum beyond the 18-bit range wraps, and is not saturated.
- R6: Dropping the low bits rounds toward minus infinity, so a unit negative impulse gives -1 on every output that sees a nonzero tap.
- R7: Inputs may be as close as 3 clocks apart. An input accepted on the same edge as the final accumulation does not change that output.
- R8: Between strobes `data_o` holds the last result.
- R9: A reset in mid-stream clears the sample history and the input parity, so the next output comes on the 2nd input after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | 18 | Input sample, signed Q16 |
| valid_o | output | 1 | Output strobe, one clock wide |
| data_o | output | 18 | Decimated sample, signed Q16 |

## Verification
Two events can fall on the same clock edge: the final multiply-accumulate, which reads the sample history, and the acceptance of a new sample, which shifts that history. The bench provokes this with inputs spaced exactly 3 clocks apart. It then compares every output, and the cycle it arrives in, against a bench model of the 11-tap sum. An output taken from the already-shifted history would fail the value check. A gap assertion in the sequencer separately flags any input that lands in an earlier step of the sequence.

// File: rtl/hb_decim_pkg.sv
package hb_decim_pkg;
  localparam int HB_DATA_W    = 18;
  localparam int HB_COEF_W    = 16;
  localparam int HB_NUM_TAPS  = 11;
  localparam int HB_FRAC_DROP = 15;

  // off-centre nonzero taps, outermost first (h[0], h[2], h[4])
  function automatic logic signed [HB_COEF_W-1:0] hb_pair_coef(input int idx);
    case (idx)
      0:       hb_pair_coef = 16'sd292;
      1:       hb_pair_coef = -16'sd1851;
      default: hb_pair_coef = 16'sd9755;
    endcase
  endfunction
endpackage

// File: rtl/hb_tap_line.sv
module hb_tap_line #(
  parameter int DATA_W   = 18,
  parameter int NUM_TAPS = 11,
  localparam int NPAIR   = (NUM_TAPS + 1) / 4,
  localparam int CENTER  = (NUM_TAPS - 1) / 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          shift_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic [NPAIR-1:0][DATA_W-1:0]  near_o,
  output logic [NPAIR-1:0][DATA_W-1:0]  far_o,
  output logic [DATA_W-1:0]             mid_o
);
  logic [NUM_TAPS-1:0][DATA_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q[0] <= '0;
    else if (shift_i) stage_q[0] <= data_i;
  end

  for (genvar s = 1; s < NUM_TAPS; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[s] <= '0;
      else if (shift_i) stage_q[s] <= stage_q[s-1];
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign near_o[p] = stage_q[2*p];
    assign far_o[p]  = stage_q[NUM_TAPS-1-2*p];
  end

  assign mid_o = stage_q[CENTER];
endmodule

// File: rtl/hb_seq.sv
module hb_seq #(
  parameter int NPAIR   = 3,
  localparam int STEP_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              busy_o,
  output logic              first_o,
  output logic              last_o,
  output logic [STEP_W-1:0] step_o
);
  logic              phase_q;
  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic              start;
  logic              at_last;

  assign start   = valid_i && phase_q;
  assign at_last = busy_q && (step_q == STEP_W'(NPAIR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= 1'b0;
    else if (valid_i) phase_q <= ~phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      step_q <= '0;
    end else if (busy_q) begin
      busy_q <= !at_last;
      step_q <= at_last ? '0 : step_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign first_o = busy_q && (step_q == '0);
  assign last_o  = at_last;
  assign step_o  = step_q;

  // R7
  input_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !at_last) |-> !valid_i);
  // R2
  odd_input_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !phase_q) |=> !busy_q);
  // R2
  start_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(valid_i));
endmodule

// File: rtl/hb_mac.sv
module hb_mac
  import hb_decim_pkg::*;
#(
  parameter int DATA_W    = 18,
  parameter int COEF_W    = 16,
  parameter int NUM_TAPS  = 11,
  parameter int FRAC_DROP = 15,
  localparam int NPAIR    = (NUM_TAPS + 1) / 4,
  localparam int STEP_W   = (NPAIR > 1) ? $clog2(NPAIR) : 1,
  localparam int PRE_W    = DATA_W + 1,
  localparam int PROD_W   = PRE_W + COEF_W,
  localparam int ACC_W    = PROD_W + $clog2(NPAIR + 1),
  localparam int MID_SHL  = COEF_W - 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NPAIR-1:0][DATA_W-1:0]  near_i,
  input  logic [NPAIR-1:0][DATA_W-1:0]  far_i,
  input  logic [DATA_W-1:0]             mid_i,
  input  logic                          busy_i,
  input  logic                          first_i,
  input  logic                          last_i,
  input  logic [STEP_W-1:0]             step_i,
  output logic                          valid_o,
  output logic [DATA_W-1:0]             data_o
);
  logic signed [PRE_W-1:0]  pre_sum [NPAIR];
  logic signed [PRE_W-1:0]  pre_sel;
  logic signed [COEF_W-1:0] coef_sel;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  mid_term;
  logic signed [ACC_W-1:0]  acc_base;
  logic signed [ACC_W-1:0]  acc_nxt;
  logic signed [ACC_W-1:0]  acc_q;
  logic [DATA_W-1:0]        data_q;
  logic                     valid_q;

  for (genvar p = 0; p < NPAIR; p++) begin : g_preadd
    assign pre_sum[p] = $signed({near_i[p][DATA_W-1], near_i[p]})
                      + $signed({far_i[p][DATA_W-1], far_i[p]});
  end

  assign pre_sel  = pre_sum[step_i];
  assign coef_sel = hb_pair_coef(int'(step_i));
  assign prod     = pre_sel * coef_sel;
  assign prod_ext = ACC_W'(prod);
  // centre coefficient 0.5 in Q15 == 1 << (COEF_W-2)
  assign mid_term = ACC_W'($signed(mid_i)) <<< MID_SHL;
  assign acc_base = first_i ? mid_term : acc_q;
  assign acc_nxt  = acc_base + prod_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (busy_i) acc_q <= acc_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= last_i;
      // floor + wrap: drop low bits, keep DATA_W
      if (last_i) data_q <= acc_nxt[FRAC_DROP +: DATA_W];
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R3
  out_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(data_q));
endmodule

// File: rtl/hb_decim_serial.sv
module hb_decim_serial
  import hb_decim_pkg::*;
#(
  parameter int DATA_W    = HB_DATA_W,
  parameter int COEF_W    = HB_COEF_W,
  parameter int NUM_TAPS  = HB_NUM_TAPS,
  parameter int FRAC_DROP = HB_FRAC_DROP,
  localparam int NPAIR    = (NUM_TAPS + 1) / 4,
  localparam int STEP_W   = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [NPAIR-1:0][DATA_W-1:0] near_taps;
  logic [NPAIR-1:0][DATA_W-1:0] far_taps;
  logic [DATA_W-1:0]            mid_tap;
  logic                         busy;
  logic                         first;
  logic                         last;
  logic [STEP_W-1:0]            step;

  hb_tap_line #(.DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS)) u_taps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (valid_i),
    .data_i  (data_i),
    .near_o  (near_taps),
    .far_o   (far_taps),
    .mid_o   (mid_tap)
  );

  hb_seq #(.NPAIR(NPAIR)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .busy_o  (busy),
    .first_o (first),
    .last_o  (last),
    .step_o  (step)
  );

  hb_mac #(
    .DATA_W    (DATA_W),
    .COEF_W    (COEF_W),
    .NUM_TAPS  (NUM_TAPS),
    .FRAC_DROP (FRAC_DROP)
  ) u_mac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .near_i  (near_taps),
    .far_i   (far_taps),
    .mid_i   (mid_tap),
    .busy_i  (busy),
    .first_i (first),
    .last_i  (last),
    .step_i  (step),
    .valid_o (valid_o),
    .data_o  (data_o)
  );

  // R3
  last_to_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> valid_o);
  // R2
  out_from_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(last));
endmodule

// File: tb/tb_hb_decim_serial.sv
module tb_hb_decim_serial;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [17:0] data_i;
  logic        valid_o;
  logic [17:0] data_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  int hist [11];
  int nin;
  logic [17:0] exp_q [$];
  int          exp_c [$];
  string       cur_tag = "R4";
  logic [17:0] last_out;

  localparam int H [11] = '{292, 0, -1851, 0, 9755, 16384, 9755, 0, -1851, 0, 292};

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hb_decim_serial dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] ref_out();
    longint acc = 0;
    longint y;
    for (int k = 0; k < 11; k++) acc += longint'(H[k]) * longint'(hist[k]);
    y = acc >>> 15;
    return y[17:0];
  endfunction

  function automatic void model_clear();
    for (int k = 0; k < 11; k++) hist[k] = 0;
    nin = 0;
    exp_q.delete();
    exp_c.delete();
  endfunction

  // call at a negedge; returns at the negedge gap cycles later
  task automatic send(input logic [17:0] x, input int gap);
    valid_i = 1'b1;
    data_i  = x;
    for (int k = 10; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = int'($signed(x));
    nin++;
    if (nin % 2 == 0) begin
      exp_q.push_back(ref_out());
      exp_c.push_back(cyc + 4);
    end
    @(negedge clk);
    valid_i = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected output", 1, 0);
      end else begin
        logic [17:0] e;
        int c;
        e = exp_q.pop_front();
        c = exp_c.pop_front();
        check(data_o == e, cur_tag, $signed(data_o), $signed(e));
        check(cyc == c, "R3 output cycle", cyc, c);
        last_out = data_o;
      end
    end
  end

  task automatic t_reset();
    check(valid_o == 1'b0, "R1 valid_o", valid_o, 0);
    check(data_o == 18'd0, "R1 data_o", data_o, 0);
  endtask

  task automatic t_impulse();
    cur_tag = "R4 impulse";
    send(18'sd32768, 16);
    for (int i = 0; i < 13; i++) send(18'd0, 16);
    drain("R2 impulse count");
  endtask

  task automatic t_mixed();
    cur_tag = "R4 mixed";
    for (int i = 0; i < 24; i++) send(18'(i * 37111 + 12345), 16);
    drain("R2 mixed count");
  endtask

  task automatic t_floor();
    cur_tag = "R6 floor";
    send(18'h3FFFF, 16);
    for (int i = 0; i < 11; i++) send(18'd0, 16);
    drain("R6 count");
  endtask

  task automatic t_wrap();
    cur_tag = "R5 wrap";
    for (int i = 0; i < 12; i++) send(18'h1FFFF, 16);
    for (int i = 0; i < 12; i++) send(18'h20000, 16);
    drain("R5 count");
  endtask

  task automatic t_tight();
    cur_tag = "R7 tight spacing";
    for (int i = 0; i < 20; i++) send(18'(i * 51929 + 777), 3);
    drain("R7 count");
  endtask

  task automatic t_hold();
    logic [17:0] v;
    cur_tag = "R4 hold setup";
    send(18'sd20000, 16);
    send(18'sd40000, 16);
    drain("R8 setup");
    v = data_o;
    check(v == last_out, "R8 value after strobe", v, last_out);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!valid_o && data_o == v, "R8 hold", data_o, v);
    end
  endtask

  task automatic t_mid_reset();
    cur_tag = "R9 after reset";
    send(18'sd50000, 16);
    rst_ni = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    check(!valid_o && data_o == 18'd0, "R9 cleared outputs", data_o, 0);
    send(18'sd1000, 16);
    send(18'sd3000, 16);
    send(18'sd0, 16);
    send(18'sd0, 16);
    drain("R9 count");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    data_i  = '0;
    last_out = '0;
    model_clear();
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_impulse();
    t_mixed();
    t_floor();
    t_wrap();
    t_tight();
    t_hold();
    t_mid_reset();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule